// File: doc/BRIEF.md
# Digit-Recurrence Natural Logarithm Unit

This sequential unit returns the natural logarithm of one positive unsigned fixed-point operand per request. The unit first finds the leading one of the operand and shifts the operand so that a mantissa in [0.5, 1) remains, together with a signed exponent correction. It then runs a multiplicative radix-2 recurrence with redundant digits {-1, 0, +1}. In that recurrence a small residual is driven towards zero, and each chosen digit adds a precomputed logarithm constant into an accumulator. At the end the exponent correction times ln 2 is added and the sum is rounded to the output format.

A request is a one-cycle `start_i` pulse with the operand on `operand_i` while the unit is idle. `busy_o` covers the computation. `done_o` marks the single cycle in which a new `result_o` is first valid. A zero operand has no logarithm, so the unit raises `err_o` and returns the most negative code. The unit handles one operand at a time.

Top module: `dr_log_unit`

## Requirements
- R1: After reset `busy_o`, `done_o` and `err_o` are low and `result_o` is zero.
- R2: A `start_i` sampled while idle with a nonzero operand raises `busy_o` from the next cycle. `done_o` is high for exactly one cycle, ITER+1 clock edges after the accepting edge (17 with defaults). `busy_o` is low whenever `done_o` is high.
- R3: A `start_i` pulse while `busy_o` is high is ignored. The running operation keeps its latency and its result.
- R4: `operand_i` is unsigned with IN_FRAC = 8 fractional bits. `result_o` is a 20-bit two's complement value with 14 fractional bits and 6 integer bits. It lies within 4 LSB of the true natural logarithm for every raw operand from 1 to 65535.
- R5: For a raw operand 2^e, the result equals (e − 8)·ln 2 within 4 LSB, for shift corrections of both signs.
- R6: The digit is +1 when the residual, truncated to 2 fractional bits, is ≥ 0. It is 0 when that estimate is in [−1, 0) and −1 below −1. Under this rule the residual stays within [−2, 1] in every iteration.
- R7: Iterations j ≤ ITER/2 add the exact constants ln(1 ± 2^−j). Later iterations add ±2^−j instead. The accuracy of R4 holds for operands whose mantissa is close to 1, where the late digits decide the result.
- R8: A zero operand sets `err_o`, returns 20'h80000 (the most negative code) and pulses `done_o` on the cycle right after the accepting edge, without raising `busy_o`.
- R9: `result_o` and `err_o` change only together with a `done_o` pulse, and a later nonzero completion clears `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse, taken only while idle |
| operand_i | input | IN_W (16) | Unsigned operand, IN_FRAC fractional bits |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle completion marker |
| err_o | output | 1 | Last completed operand was zero |
| result_o | output | RES_INT+RES_FRAC (20) | Signed logarithm, RES_FRAC fractional bits |

## Verification
On every cycle the assertions check four things. The residual stays inside its convergence band. `done_o` never overlaps `busy_o`. A nonzero request completes exactly ITER+1 edges after acceptance, and a zero request completes one edge later with the error code. They also check that the result and error flag move only on a completion. The numeric accuracy cannot be observed cycle by cycle: the split between exact table terms and linear tail terms, and the exponent correction, are shown only by the bench scenarios. Those scenarios compare each result with a real-valued logarithm over random and directed operands. Ignoring a request made during a busy interval is likewise shown only by a scenario.

// File: rtl/dr_log_pkg.sv
package dr_log_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } dl_state_e;

  // Magnitude of ln(1 + 2^-j) (neg = 0) or -ln(1 - 2^-j) (neg = 1),
  // scaled by 2^frac and rounded. j = 0 with neg = 0 gives ln 2.
  function automatic int ln_mag(input int j, input bit neg, input int frac);
    real d;
    real v;
    d = 1.0 / (2.0 ** j);
    if (neg) v = -$ln(1.0 - d);
    else     v = $ln(1.0 + d);
    return $rtoi(v * (2.0 ** frac) + 0.5);
  endfunction

endpackage

// File: rtl/dr_log_lead1.sv
module dr_log_lead1 #(
  parameter int W  = 16,
  parameter int PW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [PW-1:0] pos_o,
  output logic          none_o
);
  timeunit 1ns;
  timeprecision 1ps;

  // Highest set bit wins: scan upward, last hit overrides.
  always_comb begin
    pos_o  = '0;
    none_o = 1'b1;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) begin
        pos_o  = PW'(i);
        none_o = 1'b0;
      end
    end
  end
endmodule

// File: rtl/dr_log_rom.sv
module dr_log_rom
  import dr_log_pkg::*;
#(
  parameter int ITER  = 16,
  parameter int AF    = 20,
  parameter int OUT_W = 26,
  parameter int JW    = $clog2(ITER + 1)
) (
  input  logic [JW-1:0]    idx_i,
  input  logic             neg_i,
  output logic [OUT_W-1:0] mag_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int HALF = ITER / 2;

  logic [OUT_W-1:0] tab_p [1:HALF];
  logic [OUT_W-1:0] tab_n [1:HALF];

  for (genvar g = 1; g <= HALF; g++) begin : g_tab
    assign tab_p[g] = OUT_W'(ln_mag(g, 1'b0, AF));
    assign tab_n[g] = OUT_W'(ln_mag(g, 1'b1, AF));
  end

  // Exact constants in the first half, a plain 2^-j weight afterwards.
  always_comb begin
    mag_o = OUT_W'(1) << (AF - 32'(idx_i));
    for (int i = 1; i <= HALF; i++) begin
      if (idx_i == JW'(i)) mag_o = neg_i ? tab_n[i] : tab_p[i];
    end
  end
endmodule

// File: rtl/dr_log_step.sv
module dr_log_step #(
  parameter int WF   = 20,
  parameter int RW   = WF + 4,
  parameter int ITER = 16,
  parameter int JW   = $clog2(ITER + 1)
) (
  input  logic signed [RW-1:0] w_i,
  input  logic [JW-1:0]        j_i,
  output logic signed [RW-1:0] w_o,
  output logic                 pos_o,
  output logic                 neg_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic signed [RW-1:0] ONE =
    {{(RW-WF-1){1'b0}}, 1'b1, {WF{1'b0}}};

  // Residual estimate in units of 1/4 (floor).
  function automatic logic signed [RW-1:0] quarter_est(input logic signed [RW-1:0] w);
    return w >>> (WF - 2);
  endfunction

  // W' = 2 * (W - s + s * W * 2^-j)
  function automatic logic signed [RW-1:0] next_res(
    input logic signed [RW-1:0] w, input logic [JW-1:0] j,
    input logic p, input logic n);
    logic signed [RW-1:0] sh;
    logic signed [RW-1:0] s;
    sh = w >>> j;
    if (p)      s = w - ONE + sh;
    else if (n) s = w + ONE - sh;
    else        s = w;
    return s <<< 1;
  endfunction

  logic signed [RW-1:0] est;

  always_comb begin
    est   = quarter_est(w_i);
    pos_o = (est >= 0);
    neg_o = (est < -4);
    w_o   = next_res(w_i, j_i, pos_o, neg_o);
  end
endmodule

// File: rtl/dr_log_unit.sv
module dr_log_unit
  import dr_log_pkg::*;
#(
  parameter int IN_W     = 16,
  parameter int IN_FRAC  = 8,
  parameter int ITER     = 16,
  parameter int RES_INT  = 6,
  parameter int RES_FRAC = 14,
  parameter int GUARD    = 6
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic [IN_W-1:0]             operand_i,
  output logic                        busy_o,
  output logic                        done_o,
  output logic                        err_o,
  output logic [RES_INT+RES_FRAC-1:0] result_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int RES_W = RES_INT + RES_FRAC;
  localparam int AF    = RES_FRAC + GUARD;      // accumulator fraction bits
  localparam int ACC_W = RES_INT + AF;
  localparam int WF    = (ITER + 4 > IN_W) ? ITER + 4 : IN_W;
  localparam int RW    = WF + 4;                // sign + 3 integer bits
  localparam int JW    = $clog2(ITER + 1);
  localparam int PW    = $clog2(IN_W);
  localparam int KW    = $clog2(IN_W + IN_FRAC + 1) + 1;

  localparam logic signed [RW-1:0] ONE =
    {{(RW-WF-1){1'b0}}, 1'b1, {WF{1'b0}}};
  localparam logic signed [ACC_W-1:0] RND_HALF = ACC_W'(2 ** (GUARD - 1));
  localparam logic [RES_W-1:0] RES_MIN = {1'b1, {(RES_W-1){1'b0}}};

  dl_state_e               st_q;
  logic [JW-1:0]           j_q;
  logic signed [RW-1:0]    w_q;
  logic signed [ACC_W-1:0] y_q;
  logic signed [KW-1:0]    k_q;
  logic [RES_W-1:0]        res_q;
  logic                    err_q;
  logic                    done_q;

  // Named internal events, also watched by the checker.
  logic start_acc;
  logic run_w;
  logic dig_pos;
  logic dig_neg;
  assign start_acc = start_i && (st_q == ST_IDLE);
  assign run_w     = (st_q == ST_RUN);

  // Normalisation: leading one and mantissa in [0.5, 1).
  logic [PW-1:0]        lead_pos;
  logic                 lead_none;
  logic [IN_W-1:0]      mant;
  logic signed [RW-1:0] w_init;
  logic signed [KW-1:0] k_init;

  dr_log_lead1 #(.W(IN_W), .PW(PW)) lead_i (
    .vec_i (operand_i),
    .pos_o (lead_pos),
    .none_o(lead_none)
  );

  always_comb begin
    mant   = operand_i << (IN_W - 1 - 32'(lead_pos));
    // W1 = 2 * (1 - x), x = mant / 2^IN_W
    w_init = (ONE <<< 1) - $signed({3'b000, mant, {(WF-IN_W+1){1'b0}}});
    k_init = KW'(32'(lead_pos) + 1 - IN_FRAC);
  end

  // One recurrence step.
  logic signed [RW-1:0] w_next;

  dr_log_step #(.WF(WF), .RW(RW), .ITER(ITER), .JW(JW)) step_i (
    .w_i  (w_q),
    .j_i  (j_q),
    .w_o  (w_next),
    .pos_o(dig_pos),
    .neg_o(dig_neg)
  );

  // Constant for the current index, read once per iteration.
  logic [ACC_W-1:0]        rom_mag;
  logic signed [ACC_W-1:0] tab_s;
  logic signed [ACC_W-1:0] y_next;

  dr_log_rom #(.ITER(ITER), .AF(AF), .OUT_W(ACC_W), .JW(JW)) rom_i (
    .idx_i(j_q),
    .neg_i(dig_neg),
    .mag_o(rom_mag)
  );

  // y collects -ln(1 + s*2^-j).
  function automatic logic signed [ACC_W-1:0] acc_step(
    input logic signed [ACC_W-1:0] y, input logic signed [ACC_W-1:0] t,
    input logic p, input logic n);
    if (p)      return y - t;
    else if (n) return y + t;
    else        return y;
  endfunction

  assign tab_s  = $signed(rom_mag);
  assign y_next = acc_step(y_q, tab_s, dig_pos, dig_neg);

  // Final correction k * ln 2 and rounding to RES_FRAC bits.
  logic signed [ACC_W-1:0] ln2_c;
  logic signed [ACC_W-1:0] k_ext;
  logic signed [ACC_W-1:0] sum_fin;
  logic signed [ACC_W-1:0] rnd;
  logic [RES_W-1:0]        res_next;

  assign ln2_c = ACC_W'(ln_mag(0, 1'b0, AF));

  always_comb begin
    k_ext    = {{(ACC_W-KW){k_q[KW-1]}}, k_q};
    sum_fin  = y_q + k_ext * ln2_c;
    rnd      = sum_fin + RND_HALF;
    res_next = RES_W'(rnd >>> GUARD);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      j_q    <= '0;
      w_q    <= '0;
      y_q    <= '0;
      k_q    <= '0;
      res_q  <= '0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            if (lead_none) begin
              res_q  <= RES_MIN;
              err_q  <= 1'b1;
              done_q <= 1'b1;
            end else begin
              w_q  <= w_init;
              y_q  <= '0;
              k_q  <= k_init;
              j_q  <= JW'(1);
              st_q <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          w_q <= w_next;
          y_q <= y_next;
          if (j_q == JW'(ITER)) st_q <= ST_FIN;
          else                  j_q  <= j_q + JW'(1);
        end
        ST_FIN: begin
          res_q  <= res_next;
          err_q  <= 1'b0;
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = (st_q != ST_IDLE);
  assign done_o   = done_q;
  assign err_o    = err_q;
  assign result_o = res_q;

endmodule

// File: rtl/dr_log_unit_chk.sv
module dr_log_unit_chk #(
  parameter int ITER  = 16,
  parameter int IN_W  = 16,
  parameter int RES_W = 20,
  parameter int WF    = 20,
  parameter int RW    = 24
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 start_acc,
  input logic [IN_W-1:0]      operand_i,
  input logic                 busy_o,
  input logic                 done_o,
  input logic                 err_o,
  input logic [RES_W-1:0]     result_o,
  input logic                 run_w,
  input logic signed [RW-1:0] resid_i
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic signed [RW-1:0] HI = {{(RW-WF-1){1'b0}}, 1'b1, {WF{1'b0}}};
  localparam logic signed [RW-1:0] LO = -(HI <<< 1);
  localparam logic [RES_W-1:0] RES_MIN = {1'b1, {(RES_W-1){1'b0}}};

  int unsigned cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= 0;
    else if (start_acc) cnt_q <= 0;
    else if (busy_o)    cnt_q <= cnt_q + 1;
  end

  // R2: completion never overlaps the busy interval
  a_r2_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R2: nonzero request completes ITER+1 edges after acceptance
  a_r2_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> (cnt_q == ITER + 1));

  // R6: residual held within [-2, 1] during iterations
  a_r6_resid_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_w |-> (resid_i >= LO && resid_i <= HI));

  // R8: zero operand reports the error code one edge later
  a_r8_zero_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_acc && operand_i == '0) |=> (done_o && err_o && result_o == RES_MIN && !busy_o));

  // R9: result and error flag move only with a completion
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(result_o) || !$stable(err_o)) |-> done_o);

endmodule

bind dr_log_unit dr_log_unit_chk #(
  .ITER (ITER),
  .IN_W (IN_W),
  .RES_W(RES_W),
  .WF   (WF),
  .RW   (RW)
) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_acc(start_acc),
  .operand_i(operand_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .err_o    (err_o),
  .result_o (result_o),
  .run_w    (run_w),
  .resid_i  (w_q)
);

// File: tb/dr_log_unit_tb_top.sv
module dr_log_unit_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int IN_W = 16;
  localparam int IN_FRAC = 8;
  localparam int ITER = 16;
  localparam int RES_W = 20;
  localparam int RES_FRAC = 14;
  localparam real TOL = 4.0;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [IN_W-1:0]  operand = '0;
  logic             busy, done, err;
  logic [RES_W-1:0] result;

  int n_chk = 0;
  int n_err = 0;
  bit ended = 1'b0;

  always #2.5 clk = ~clk;

  dr_log_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .operand_i(operand),
    .busy_o(busy), .done_o(done), .err_o(err), .result_o(result)
  );

  function automatic real ref_ln(input int raw);
    return $ln(real'(raw) / (2.0 ** IN_FRAC)) * (2.0 ** RES_FRAC);
  endfunction

  task automatic chk(input bit ok, input string req, input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  // Issue one request; optional extra start while busy (R3).
  task automatic run_op(input logic [IN_W-1:0] v, input bit poke, input string req);
    int cyc;
    bit busy_bad;
    real exp_v;
    int got;
    logic [RES_W-1:0] held;
    @(negedge clk);
    start = 1'b1;
    operand = v;
    @(negedge clk);
    start = 1'b0;
    operand = IN_W'($urandom);
    cyc = 0;
    busy_bad = 1'b0;
    while (!done && cyc < 200) begin
      if (!busy) busy_bad = 1'b1;
      start = poke && (cyc == 3);
      operand = (v == 0) ? 16'h1234 : '0;
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    if (v == 0) begin
      // R8
      chk(cyc == 0 && err && result == 20'h80000 && !busy, "R8 zero operand",
          $sformatf("cyc=%0d err=%0b res=%h busy=%0b", cyc, err, result, busy),
          "cyc=0 err=1 res=80000 busy=0");
    end else begin
      chk(cyc == ITER + 1 && !busy_bad && !busy, poke ? "R3 busy start ignored" : "R2 latency",
          $sformatf("edges=%0d busy_gap=%0b busy_at_done=%0b", cyc, busy_bad, busy),
          $sformatf("edges=%0d busy_gap=0 busy_at_done=0", ITER + 1));
      exp_v = ref_ln(int'(v));
      got = $signed(result);
      chk(!err && (real'(got) - exp_v <= TOL) && (exp_v - real'(got) <= TOL), req,
          $sformatf("v=%h res=%0d err=%0b", v, got, err), $sformatf("%.2f err=0", exp_v));
    end
    held = result;
    @(negedge clk);
    // R2 single pulse, R9 values held
    chk(!done && result == held, "R2/R9 pulse and hold",
        $sformatf("done=%0b res=%h", done, result), $sformatf("done=0 res=%h", held));
  endtask

  initial begin
    #(5.0 * 150000);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    // R1
    chk(!busy && !done && !err && result == '0, "R1 reset",
        $sformatf("b=%0b d=%0b e=%0b r=%h", busy, done, err, result), "all zero");
    rst_n = 1'b1;
    @(negedge clk);

    // R5 powers of two, both signs of correction
    for (int e = 0; e < IN_W; e++) run_op(IN_W'(1) << e, 1'b0, "R5 power of two");
    // R4 extremes
    run_op(16'hFFFF, 1'b0, "R4 max operand");
    run_op(16'h0003, 1'b0, "R4 small operand");
    // R7 mantissa near one
    run_op(16'h0101, 1'b0, "R7 near one above");
    run_op(16'h00FF, 1'b0, "R7 near one below");
    run_op(16'h7FFF, 1'b0, "R7 mantissa max");
    // R8 then R9 error clear
    run_op(16'h0000, 1'b0, "R8");
    run_op(16'h0000, 1'b0, "R8");
    run_op(16'h1A2B, 1'b0, "R9 after error");
    chk(!err, "R9 error cleared", $sformatf("%0b", err), "0");
    // R3 request during busy
    run_op(16'h0C35, 1'b1, "R3 result kept");
    run_op(16'h0000, 1'b1, "R8");
    // Random operands over the whole range (R4)
    for (int i = 0; i < 300; i++) begin
      logic [IN_W-1:0] v;
      v = IN_W'($urandom_range(65535, 1) >> $urandom_range(15, 0));
      if (v == 0) v = 16'h0001;
      run_op(v, (i % 17) == 5, "R4 random");
    end
    finish_run();
  end
endmodule